// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block is a memory-mapped watchdog. A 32-bit counter is loaded from a programmable reload register and counts down. Software keeps the system alive by writing one exact key word to a restart address, which reloads the counter. If the count runs out, the block asks for a system reset, carries a reset-mode code beside that request, and fires a one-cycle trigger for an external pulse stretcher. It also records the expiry in sticky status bits. One of those bits marks that the next boot should come from the secondary device.

An early-warning interrupt can be armed. It fires when the counter passes a threshold held in the upper bits of the control word, so software still has time to react before the reset. A built-in prescaler divides the system clock into a slow tick. A control bit chooses between that tick and the raw system clock as the count step. The register port is a plain single-cycle interface. Reads are combinational, and writes take effect at the next clock edge.

The control sequencer is a three-state machine:
- `ST_HALT` means counting is disabled.
- `ST_COUNT` means the counter is running.
- `ST_EXPIRE` is a one-cycle state that drives the expiry outputs.

Its transitions are:
- HALT→COUNT when the run bit is set.
- COUNT→HALT when the run bit is cleared.
- COUNT→EXPIRE when a step arrives at count zero with no restart in the same cycle.
- EXPIRE→COUNT when the run bit is still set.
- EXPIRE→HALT otherwise.

Top module: `wdog_timer`

## Requirements
- R1: After reset the count (offset 0x00) and reload (0x04) read RESET_LOAD, control (0x0C) and status (0x10) read 0, the width register (0x18) reads 0xFF, and the irq, rst_req, ext_trig and boot_alt outputs are low. Offsets 0x08 and 0x14 read 0.
- R2: A write of exactly 0x00004755 to offset 0x08 sets the count to the reload value on the next clock. A write of any other value there leaves the count unchanged.
- R3: While control bit 0 (run) is 0 the count holds its value, and a write to the reload register does not change the count.
- R4: With run set and control bit 4 clear, the count steps on every clock. Expiry pulses then repeat every reload+2 clocks: reload+1 steps plus one cycle in the expiry state.
- R5: With control bit 4 set, the count steps once every TICK_DIV clocks, and expiry pulses repeat every (reload+1)·TICK_DIV clocks.
- R6: Expiry happens on a step taken at count 0. It reloads the count, raises ext_trig for exactly one clock if control bit 3 is set, raises rst_req for exactly one clock if control bit 1 is set, and sets status bit 0.
- R7: The rst_mode output follows control bits 6:5. Code 0 selects SoC reset, 1 selects full-chip reset, and 2 selects CPU-only reset.
- R8: While run and control bit 2 are set, the count equals {control[31:10], 10'b0} at a clock edge sets status bit 2 and raises wdt_irq at that edge. With control bit 2 clear, wdt_irq never rises.
- R9: wdt_irq stays high until a clear write, or until the clock after control bit 2 reads back as 0.
- R10: An expiry with control bit 7 set sets status bit 1 and raises boot_alt. Both stay set until a clear write, even when the watchdog is stopped.
- R11: A write to offset 0x14 with bit 0 set clears status bits 2:0. A write there with bit 0 clear has no effect.
- R12: The low 20 bits of offset 0x18 are read/write and drive ext_width. The upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| wdt_irq | output | 1 | Early-warning interrupt, level |
| rst_req | output | 1 | One-cycle reset request on expiry |
| rst_mode | output | 2 | Reset scope code (control bits 6:5) |
| ext_trig | output | 1 | One-cycle trigger for the external reset pulse |
| boot_alt | output | 1 | Sticky boot-from-secondary flag |
| ext_width | output | 20 | External pulse width setting |

## Verification
The bench builds the block with TICK_DIV=4 and RESET_LOAD=1000. The short prescale lets it sweep expiry periods exhaustively:
- every reload value from 0 to 20 in per-clock stepping;
- every reload value from 0 to 6 in prescaled stepping.

Each measured period is compared with the arithmetic expectation. The small reset load keeps the reset-state readback cheap. A reload of 1500 makes the counter pass the first non-zero threshold (1024) within a few thousand clocks. This brings the exact interrupt cycle, the sticky hold and both interrupt clearing paths within reach.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int ADDR_W = 5;
    localparam int WORD_W = 32;

    localparam logic [ADDR_W-1:0] A_COUNT   = 5'h00;
    localparam logic [ADDR_W-1:0] A_RELOAD  = 5'h04;
    localparam logic [ADDR_W-1:0] A_RESTART = 5'h08;
    localparam logic [ADDR_W-1:0] A_CTRL    = 5'h0C;
    localparam logic [ADDR_W-1:0] A_STATUS  = 5'h10;
    localparam logic [ADDR_W-1:0] A_CLEAR   = 5'h14;
    localparam logic [ADDR_W-1:0] A_WIDTH   = 5'h18;

    localparam logic [WORD_W-1:0] KICK_WORD = 32'h0000_4755;

    // control word bit positions
    localparam int C_RUN     = 0;
    localparam int C_RSTEN   = 1;
    localparam int C_IRQEN   = 2;
    localparam int C_EXTEN   = 3;
    localparam int C_SLOWCLK = 4;
    localparam int C_MODE_LO = 5;
    localparam int C_ALTBOOT = 7;
    localparam int C_THR_LO  = 10;

    // status word bit positions
    localparam int S_EXPIRED = 0;
    localparam int S_ALTBOOT = 1;
    localparam int S_EARLY   = 2;

    typedef enum logic [1:0] {
        ST_HALT,
        ST_COUNT,
        ST_EXPIRE
    } wd_state_t;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    always_comb tick = (phase_q == LAST);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter logic [CNT_W-1:0] INIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic             kick,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    wd_state_t        state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic             at_zero;

    always_comb at_zero = (count_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_HALT;
        else
            state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:   if (run) state_d = ST_COUNT;
            ST_COUNT: begin
                if (!run)
                    state_d = ST_HALT;
                else if (step && at_zero && !kick)
                    state_d = ST_EXPIRE;
            end
            ST_EXPIRE: state_d = run ? ST_COUNT : ST_HALT;
            default:   state_d = ST_HALT;
        endcase
    end

    // counter datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_q <= INIT;
        else if (kick)
            count_q <= reload;
        else if (state_q == ST_COUNT && run && step)
            count_q <= at_zero ? reload : count_q - 1'b1;
    end

    // outputs
    always_comb begin
        expire = (state_q == ST_EXPIRE);
        count  = count_q;
    end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int          TICK_DIV   = 50,
    parameter logic [31:0] RESET_LOAD = 32'd30_000_000,
    parameter int          WIDTH_W    = 20,
    parameter logic [WIDTH_W-1:0] WIDTH_INIT = WIDTH_W'(8'hFF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [4:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               wdt_irq,
    output logic               rst_req,
    output logic [1:0]         rst_mode,
    output logic               ext_trig,
    output logic               boot_alt,
    output logic [WIDTH_W-1:0] ext_width
);
    localparam int THR_W = WORD_W - C_THR_LO;

    logic [WORD_W-1:0]  ctrl_q;
    logic [WORD_W-1:0]  reload_q;
    logic [2:0]         status_q;
    logic [WIDTH_W-1:0] width_q;
    logic [WORD_W-1:0]  cur_count;
    logic               wr_en, kick, clr, tick, step, expire, early_hit;
    logic [WORD_W-1:0]  threshold;

    always_comb begin
        wr_en     = bus_sel && bus_wr;
        kick      = wr_en && (bus_addr == A_RESTART) && (bus_wdata == KICK_WORD);
        clr       = wr_en && (bus_addr == A_CLEAR) && bus_wdata[0];
        step      = ctrl_q[C_SLOWCLK] ? tick : 1'b1;
        threshold = {ctrl_q[WORD_W-1:C_THR_LO], {C_THR_LO{1'b0}}};
        early_hit = ctrl_q[C_RUN] && ctrl_q[C_IRQEN] && (cur_count == threshold);
    end

    wdog_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    wdog_core #(.CNT_W(WORD_W), .INIT(RESET_LOAD)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctrl_q[C_RUN]),
        .step   (step),
        .kick   (kick),
        .reload (reload_q),
        .count  (cur_count),
        .expire (expire)
    );

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= RESET_LOAD;
            width_q  <= WIDTH_INIT;
        end else if (wr_en) begin
            if (bus_addr == A_CTRL)   ctrl_q   <= bus_wdata;
            if (bus_addr == A_RELOAD) reload_q <= bus_wdata;
            if (bus_addr == A_WIDTH)  width_q  <= bus_wdata[WIDTH_W-1:0];
        end
    end

    // sticky status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (clr) begin
            status_q <= '0;
        end else begin
            if (expire)                          status_q[S_EXPIRED] <= 1'b1;
            if (expire && ctrl_q[C_ALTBOOT])     status_q[S_ALTBOOT] <= 1'b1;
            if (!ctrl_q[C_IRQEN])                status_q[S_EARLY]   <= 1'b0;
            else if (early_hit)                  status_q[S_EARLY]   <= 1'b1;
        end
    end

    // read mux
    always_comb begin
        case (bus_addr)
            A_COUNT:  bus_rdata = cur_count;
            A_RELOAD: bus_rdata = reload_q;
            A_CTRL:   bus_rdata = ctrl_q;
            A_STATUS: bus_rdata = {{(WORD_W-3){1'b0}}, status_q};
            A_WIDTH:  bus_rdata = {{(WORD_W-WIDTH_W){1'b0}}, width_q};
            default:  bus_rdata = '0;
        endcase
    end

    // outputs
    always_comb begin
        wdt_irq   = status_q[S_EARLY];
        boot_alt  = status_q[S_ALTBOOT];
        rst_req   = expire && ctrl_q[C_RSTEN];
        ext_trig  = expire && ctrl_q[C_EXTEN];
        rst_mode  = ctrl_q[C_MODE_LO+1:C_MODE_LO];
        ext_width = width_q;
    end

    if (THR_W < 1) begin : g_bad_thr
        initial $display("threshold field is empty");
    end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [4:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        wdt_irq,
    input logic        rst_req,
    input logic        ext_trig,
    input logic        boot_alt,
    input logic [31:0] ctrl_q,
    input logic [31:0] reload_q,
    input logic [31:0] cur_count
);
    logic key_wr, clear_wr;
    always_comb begin
        key_wr   = bus_sel && bus_wr && bus_addr == 5'h08 && bus_wdata == 32'h4755;
        clear_wr = bus_sel && bus_wr && bus_addr == 5'h14 && bus_wdata[0];
    end

    // R2
    key_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> cur_count == $past(reload_q));

    // R3
    frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[0] && !key_wr) |=> $stable(cur_count));

    // R6
    trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_trig |=> !ext_trig);

    // R6
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R8
    irq_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_irq) |-> $past(ctrl_q[2]));

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_irq && ctrl_q[2] && !clear_wr) |=> wdt_irq);

    // R10
    boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_alt && !clear_wr) |=> boot_alt);
endmodule

bind wdog_timer wdog_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .wdt_irq   (wdt_irq),
    .rst_req   (rst_req),
    .ext_trig  (ext_trig),
    .boot_alt  (boot_alt),
    .ctrl_q    (ctrl_q),
    .reload_q  (reload_q),
    .cur_count (cur_count)
);

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
    localparam int DIV  = 4;
    localparam int LOAD = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_irq, rst_req, ext_trig, boot_alt;
    logic [1:0]  rst_mode;
    logic [19:0] ext_width;

    int checks = 0;
    int errors = 0;

    wdog_timer #(.TICK_DIV(DIV), .RESET_LOAD(32'(LOAD))) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_irq(wdt_irq), .rst_req(rst_req), .rst_mode(rst_mode),
        .ext_trig(ext_trig), .boot_alt(boot_alt), .ext_width(ext_width)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // wait until ext_trig is sampled high
    task automatic wait_trig();
        int n = 0;
        while (!ext_trig && n < 5000) begin
            @(posedge clk); #1; n++;
        end
    endtask

    // measure clocks between two ext_trig pulses; also check pulse width
    task automatic period(input string tag, output int n);
        wait_trig();
        @(posedge clk); #1;
        chk({tag, " trig width"}, 32'(ext_trig), 32'd0);
        n = 1;
        while (!ext_trig && n < 5000) begin
            @(posedge clk); #1; n++;
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v, v2;
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(5'h00, v); chk("R1 count", v, LOAD);
        rd(5'h04, v); chk("R1 reload", v, LOAD);
        rd(5'h0C, v); chk("R1 ctrl", v, 0);
        rd(5'h10, v); chk("R1 status", v, 0);
        rd(5'h18, v); chk("R1 width", v, 32'hFF);
        rd(5'h08, v); chk("R1 restart reads 0", v, 0);
        rd(5'h14, v); chk("R1 clear reads 0", v, 0);
        chk("R1 outputs", {wdt_irq, rst_req, ext_trig, boot_alt}, 0);

        // R3 reload write leaves count alone; R2 key handling
        wr(5'h04, 77);
        rd(5'h00, v); chk("R3 reload write no count change", v, LOAD);
        wr(5'h08, 32'h1234);
        rd(5'h00, v); chk("R2 wrong key ignored", v, LOAD);
        wr(5'h08, 32'h4755);
        rd(5'h00, v); chk("R2 key reloads", v, 77);
        wr(5'h04, 5);
        wr(5'h08, 32'h0001_4755);
        rd(5'h00, v); chk("R2 near-key ignored", v, 77);

        // R3 freeze
        wr(5'h04, 77); wr(5'h08, 32'h4755);
        wr(5'h0C, 32'h1);
        cyc(10);
        wr(5'h0C, 32'h0);
        rd(5'h00, v); cyc(7); rd(5'h00, v2);
        chk("R3 frozen", v2, v);
        chk("R3 counted before freeze", 32'(v < 77), 1);

        // R4 per-clock sweep
        for (int r = 0; r <= 20; r++) begin
            wr(5'h0C, 0); wr(5'h04, 32'(r)); wr(5'h08, 32'h4755);
            wr(5'h0C, 32'h9);
            period("R4", n);
            chk($sformatf("R4 period reload %0d", r), 32'(n), 32'(r + 2));
        end
        rd(5'h10, v); chk("R6 status expired bit", v & 32'h1, 1);

        // R5 prescaled sweep
        for (int r = 0; r <= 6; r++) begin
            wr(5'h0C, 0); wr(5'h04, 32'(r)); wr(5'h08, 32'h4755);
            wr(5'h0C, 32'h19);
            period("R5", n);
            chk($sformatf("R5 period reload %0d", r), 32'(n), 32'((r + 1) * DIV));
        end

        // R7 mode codes
        for (int m = 0; m <= 2; m++) begin
            wr(5'h0C, 32'(m) << 5);
            chk($sformatf("R7 mode %0d", m), 32'(rst_mode), 32'(m));
        end

        // R6 / R10 / R11 reset request and boot flag
        wr(5'h0C, 0); wr(5'h14, 1);
        wr(5'h04, 5); wr(5'h08, 32'h4755);
        wr(5'h0C, 32'h83 | (32'd2 << 5));
        n = 0;
        while (!rst_req && n < 5000) begin @(posedge clk); #1; n++; end
        chk("R6 rst_req seen", 32'(rst_req), 1);
        chk("R6 no ext_trig when bit3 clear", 32'(ext_trig), 0);
        chk("R7 mode during request", 32'(rst_mode), 2);
        cyc(1);
        chk("R6 rst_req one cycle", 32'(rst_req), 0);
        rd(5'h10, v); chk("R10 status", v, 3);
        chk("R10 boot_alt", 32'(boot_alt), 1);
        wr(5'h0C, 0); cyc(3);
        chk("R10 boot_alt held when stopped", 32'(boot_alt), 1);
        wr(5'h14, 0);
        chk("R11 clear bit0=0 no effect", 32'(boot_alt), 1);
        wr(5'h14, 1);
        rd(5'h10, v); chk("R11 clear", v, 0);
        chk("R11 boot_alt cleared", 32'(boot_alt), 0);

        // R8 / R9 early warning
        wr(5'h04, 1500); wr(5'h08, 32'h4755);
        wr(5'h0C, (32'd1 << 10) | 32'h5);
        n = 0;
        while (!wdt_irq && n < 5000) begin @(posedge clk); #1; n++; end
        rd(5'h00, v); chk("R8 irq at threshold", v, 1024 - 1);
        rd(5'h10, v); chk("R8 status early bit", v, 4);
        cyc(10);
        chk("R9 irq held", 32'(wdt_irq), 1);
        wr(5'h14, 0);
        chk("R11 irq not cleared by bit0=0", 32'(wdt_irq), 1);
        wr(5'h14, 1);
        chk("R9 irq cleared by clear write", 32'(wdt_irq), 0);
        n = 0;
        while (!wdt_irq && n < 5000) begin @(posedge clk); #1; n++; end
        chk("R8 irq again next pass", 32'(wdt_irq), 1);
        wr(5'h0C, (32'd1 << 10) | 32'h1);
        cyc(1);
        chk("R9 irq dropped with enable", 32'(wdt_irq), 0);
        n = 0;
        for (int i = 0; i < 3200; i++) begin
            @(posedge clk); #1;
            if (wdt_irq) n++;
        end
        chk("R8 no irq when disarmed", 32'(n), 0);
        rd(5'h10, v); chk("R8 early bit stays clear", v & 32'h4, 0);
        wr(5'h0C, 0);

        // R12 width register
        wr(5'h18, 32'hFFF1_2345);
        rd(5'h18, v); chk("R12 width readback", v, 32'h1_2345);
        chk("R12 ext_width", 32'(ext_width), 32'h1_2345);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule